// File: doc/BRIEF.md
# I2C Target Register Bank

This block is a target device on a two-wire serial bus that exposes a small bank of byte-wide registers to a bus controller. It oversamples SCL and SDA with the system clock, finds START, repeated START and STOP conditions, and compares the 7-bit address of each transfer with its own. The upper address bits are fixed by a parameter and the low bits come from strap inputs tied high or low on the board, so several copies can share one bus.

A write transfer uses its first data byte to load an internal register pointer; every later byte in that transfer is stored at the pointer, which then steps forward and wraps at the end of the bank. A read transfer returns the register at the pointer, MSB first, again stepping the pointer after each byte. The pointer is kept across STOP and repeated START, so the usual "write pointer, repeated START, read" sequence returns the chosen register. When the bank reports it is not ready, the block holds SCL low at the end of an acknowledge clock until the bank becomes ready.

The controller is an enumerated state machine. Its states are IDLE (wait for START), ADDR (shift in address and R/W), ADDR_ACK (drive the address acknowledge), WR_BYTE (shift in a data byte), WR_ACK (drive the data acknowledge), RD_BYTE (shift out a register byte), RD_ACK (sample the controller's acknowledge) and HOLD (stretch SCL). Transitions: START from any state goes to ADDR; STOP from any state goes to IDLE; ADDR goes to ADDR_ACK on a match and to IDLE otherwise; ADDR_ACK goes to WR_BYTE (write) or RD_BYTE (read); WR_BYTE goes to WR_ACK after eight bits; WR_ACK goes back to WR_BYTE; RD_BYTE goes to RD_ACK after eight bits; RD_ACK goes to RD_BYTE on ACK and to IDLE on NACK; each exit from ADDR_ACK, WR_ACK or RD_ACK detours through HOLD while the bank is not ready.

Top module: `i2c_regbank_target`

## Requirements
- R1: The device address is {FIXED_ADDR[6:STRAP_W], strap_i}; with the defaults (FIXED_ADDR = 7'h50, STRAP_W = 2) and strap_i = 2'b11 the address is 7'h53, and a matching address byte is acknowledged by SDA low during the ninth clock.
- R2: An address byte that does not match is not acknowledged, and SDA stays released for the rest of that transfer.
- R3: START is SDA falling and STOP is SDA rising while SCL is high; SDA changes while SCL is low are data, and the block changes its own SDA drive only while SCL is low.
- R4: In a write (R/W bit = 0, the LSB of the address byte), the first data byte loads the pointer from its low log2(NUM_REGS) bits; each further byte is written to the register at the pointer; every byte is acknowledged.
- R5: The pointer increases by one after every data byte written or read and wraps from NUM_REGS-1 to 0.
- R6: In a read (R/W = 1) the block sends the register at the pointer MSB first; the pointer survives STOP and repeated START, so a repeated START after a pointer write returns the selected register.
- R7: A controller NACK after a read byte ends the transfer and SDA stays released until the next START.
- R8: A START or STOP in the middle of a byte discards the partial byte, clears the bit count and restarts address matching; nothing is written.
- R9: After reset register i holds RESET_BASE + i (default 8'h30 + i), the pointer is 0 and neither line is driven.
- R10: With STRETCH_EN = 1, if bank_ready is low at the falling SCL edge that ends an acknowledge clock, SCL is held low until bank_ready is high, then released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL bus line |
| sda_i | input | 1 | Sampled level of the SDA bus line |
| strap_i | input | STRAP_W | Board straps forming the low address bits |
| bank_ready | input | 1 | Register bank ready; low requests clock stretching |
| scl_drive_low | output | 1 | Pull SCL low (open-drain enable) |
| sda_drive_low | output | 1 | Pull SDA low (open-drain enable) |

## Verification
The hardest situation to reach is a condition arriving in the middle of a byte: the bench has to stop clocking after a few bits and then bend SDA while SCL is high, and only a later read-back shows that the partial byte did not reach the bank. The bench models the bus as wired-AND of its own open-drain controller and the block's drives, so it can cut a byte after three or four bits, issue STOP or repeated START, and then re-address the target. Clock stretching is reached by lowering bank_ready in a parallel thread while a write runs, and the controller's wait for SCL to rise is timed.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    // Target controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_HOLD
    } tgt_state_e;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Idle bus is high, so every stage resets high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  =  scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl &  scl_q;
    // SDA moving while SCL stayed high over both samples
    assign start_evt = scl_lvl & scl_q &  sda_q & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_q & ~sda_q &  sda_lvl;

endmodule

// File: rtl/i2c_reg_store.sv
module i2c_reg_store #(
    parameter int NUM_REGS   = 8,
    parameter int RESET_BASE = 'h30,
    localparam int PTR_W     = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [7:0]       wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [7:0]       rd_data
);

    // NUM_REGS is expected to be a power of two so the pointer wraps naturally
    logic [7:0] regs [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs[i] <= 8'(RESET_BASE + i);
            end
        end else if (wr_en) begin
            regs[wr_ptr] <= wr_data;
        end
    end

    assign rd_data = regs[rd_ptr];

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs[$past(wr_ptr)] == $past(wr_data));

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_rf_pkg::*;
#(
    parameter int         STRAP_W    = 2,
    parameter logic [6:0] FIXED_ADDR = 7'h50,
    parameter int         NUM_REGS   = 8,
    parameter int         RESET_BASE = 'h30,
    parameter bit         STRETCH_EN = 1'b1,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               bank_ready,
    output logic               scl_drive_low,
    output logic               sda_drive_low
);

    localparam int PTR_W = $clog2(NUM_REGS);

    // Line conditioning
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    // Own address: fixed high part, strapped low part
    logic [6:0] my_addr;
    assign my_addr = {FIXED_ADDR[6:STRAP_W], strap_i};

    // Stretch variant selection
    logic stretch_req;
    generate
        if (STRETCH_EN) begin : g_stretch
            assign stretch_req = ~bank_ready;
        end else begin : g_no_stretch
            assign stretch_req = 1'b0;
        end
    endgenerate

    // State and datapath registers
    tgt_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BYTE_W-1:0] rx_q, rx_d;
    logic [BYTE_W-1:0] tx_q, tx_d;
    logic [PTR_W-1:0]  ptr_q, ptr_d;
    logic              full_q, full_d;
    logic              first_q, first_d;
    logic              mack_q, mack_d;
    logic              hold_rd_q, hold_rd_d;
    logic              rw_q, rw_d;
    logic              wr_en;
    logic              ptr_step;
    logic [7:0]        rd_data;

    i2c_reg_store #(.NUM_REGS(NUM_REGS), .RESET_BASE(RESET_BASE)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (ptr_q),
        .wr_data (rx_q),
        .rd_ptr  (ptr_q),
        .rd_data (rd_data)
    );

    // Next state and datapath
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        rx_d      = rx_q;
        tx_d      = tx_q;
        ptr_d     = ptr_q;
        full_d    = full_q;
        first_d   = first_q;
        mack_d    = mack_q;
        hold_rd_d = hold_rd_q;
        rw_d      = rw_q;
        wr_en     = 1'b0;
        ptr_step  = 1'b0;

        if (start_evt) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
            full_d  = 1'b0;
        end else if (stop_evt) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            full_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        rx_d  = {rx_q[BYTE_W-2:0], sda_lvl};
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(BYTE_W - 1)) full_d = 1'b1;
                    end else if (scl_fall && full_q) begin
                        full_d = 1'b0;
                        cnt_d  = '0;
                        if (state_q == ST_ADDR) begin
                            if (rx_q[7:1] == my_addr) begin
                                state_d = ST_ADDR_ACK;
                                rw_d    = rx_q[0];
                            end else begin
                                state_d = ST_IDLE;
                            end
                        end else begin
                            state_d = ST_WR_ACK;
                            if (first_q) begin
                                ptr_d = rx_q[PTR_W-1:0];
                            end else begin
                                wr_en    = 1'b1;
                                ptr_step = 1'b1;
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        first_d = (state_q == ST_ADDR_ACK);
                        cnt_d   = '0;
                        if (stretch_req) begin
                            state_d   = ST_HOLD;
                            hold_rd_d = (state_q == ST_ADDR_ACK) && rw_q;
                        end else if ((state_q == ST_ADDR_ACK) && rw_q) begin
                            tx_d    = rd_data;
                            state_d = ST_RD_BYTE;
                        end else begin
                            state_d = ST_WR_BYTE;
                        end
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                            state_d  = ST_RD_ACK;
                            ptr_step = 1'b1;
                            mack_d   = 1'b0;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) state_d = ST_IDLE;
                        else         mack_d  = 1'b1;
                    end else if (scl_fall && mack_q) begin
                        cnt_d = '0;
                        if (stretch_req) begin
                            state_d   = ST_HOLD;
                            hold_rd_d = 1'b1;
                        end else begin
                            tx_d    = rd_data;
                            state_d = ST_RD_BYTE;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!stretch_req) begin
                        cnt_d = '0;
                        if (hold_rd_q) begin
                            tx_d    = rd_data;
                            state_d = ST_RD_BYTE;
                        end else begin
                            state_d = ST_WR_BYTE;
                        end
                    end
                end
            endcase
        end

        if (ptr_step) ptr_d = ptr_q + PTR_W'(1);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            ptr_q     <= '0;
            full_q    <= 1'b0;
            first_q   <= 1'b0;
            mack_q    <= 1'b0;
            hold_rd_q <= 1'b0;
            rw_q      <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            rx_q      <= rx_d;
            tx_q      <= tx_d;
            ptr_q     <= ptr_d;
            full_q    <= full_d;
            first_q   <= first_d;
            mack_q    <= mack_d;
            hold_rd_q <= hold_rd_d;
            rw_q      <= rw_d;
        end
    end

    // Outputs
    always_comb begin
        sda_drive_low = 1'b0;
        scl_drive_low = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_drive_low = 1'b1;
            ST_RD_BYTE:             sda_drive_low = ~tx_q[BYTE_W-1];
            ST_HOLD:                scl_drive_low = 1'b1;
            default: begin
            end
        endcase
    end

    // Checks next to the logic they guard
    assert_ptr_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_step |=> ptr_q == $past(ptr_q) + PTR_W'(1));

    assert_start_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state_q == ST_ADDR) && (cnt_q == '0));

    assert_stop_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !start_evt) |=> state_q == ST_IDLE);

    assert_sda_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_lvl);

    assert_stretch_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bank_ready) |-> !scl_drive_low);

endmodule

// File: tb/i2c_regbank_target_tb.sv
module i2c_regbank_target_tb;

    localparam int         HP       = 8;
    localparam logic [6:0] DUT_ADDR = 7'h53;

    typedef struct packed {
        logic [7:0] ptr;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{ptr: 8'h00, data: 8'hA5},
        '{ptr: 8'h01, data: 8'h5A},
        '{ptr: 8'h02, data: 8'hFF},
        '{ptr: 8'h04, data: 8'h00},
        '{ptr: 8'h07, data: 8'h81},
        '{ptr: 8'h0D, data: 8'h3C}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap = 2'b11;
    logic       bank_ready = 1'b1;
    logic       scl_drive_low, sda_drive_low;
    logic       scl_bus, sda_bus;

    int n_checks = 0;
    int n_fail   = 0;
    int stretch_max = 0;
    logic [7:0] model [8];

    always #10 clk = ~clk;

    assign scl_bus = m_scl & ~scl_drive_low;
    assign sda_bus = m_sda & ~sda_drive_low;

    i2c_regbank_target u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_bus),
        .sda_i         (sda_bus),
        .strap_i       (strap),
        .bank_ready    (bank_ready),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        m_sda = 1'b1;
        wclk(HP);
        m_scl = 1'b1;
        while (!scl_bus) @(negedge clk);
        wclk(HP);
        m_sda = 1'b0;
        wclk(HP);
        m_scl = 1'b0;
        wclk(HP);
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0;
        wclk(HP);
        m_scl = 1'b1;
        while (!scl_bus) @(negedge clk);
        wclk(HP);
        m_sda = 1'b1;
        wclk(HP);
    endtask

    task automatic clock_bit(input logic b, output logic r);
        int w;
        m_sda = b;
        wclk(HP);
        m_scl = 1'b1;
        w = 0;
        while (!scl_bus) begin
            @(negedge clk);
            w++;
        end
        if (w > stretch_max) stretch_max = w;
        wclk(HP / 2);
        r = sda_bus;
        wclk(HP / 2);
        m_scl = 1'b0;
        wclk(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
        clock_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, r);
            b[i] = r;
        end
        clock_bit(~give_ack, r);
    endtask

    task automatic wr_burst(input logic [7:0] ptr, input int n, input logic [23:0] dat,
                            output logic all_ack);
        logic a;
        i2c_start();
        send_byte({DUT_ADDR, 1'b0}, a);
        all_ack = a;
        send_byte(ptr, a);
        all_ack &= a;
        for (int i = 0; i < n; i++) begin
            logic [2:0] idx;
            send_byte(dat[8*i +: 8], a);
            all_ack &= a;
            idx = ptr[2:0] + 3'(i);
            model[idx] = dat[8*i +: 8];
        end
        i2c_stop();
    endtask

    task automatic rd_burst(input logic set_ptr, input logic [7:0] ptr, input int n,
                            output logic [23:0] got);
        logic a;
        logic [7:0] b;
        got = '0;
        i2c_start();
        if (set_ptr) begin
            send_byte({DUT_ADDR, 1'b0}, a);
            send_byte(ptr, a);
            i2c_start();
        end
        send_byte({DUT_ADDR, 1'b1}, a);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            got[8*i +: 8] = b;
        end
        i2c_stop();
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic       ok, a, r;
        logic [23:0] got;
        logic [7:0]  b;

        for (int i = 0; i < 8; i++) model[i] = 8'(8'h30 + i);
        wclk(5);
        // R9: lines released during and after reset
        check("R9 sda released at reset", sda_drive_low, 1'b0);
        check("R9 scl released at reset", scl_drive_low, 1'b0);
        rst_n = 1'b1;
        wclk(5);

        // R9: pointer starts at 0, register 0 holds its reset value
        rd_burst(1'b0, 8'h00, 1, got);
        check("R9 reset pointer read", got[7:0], 8'h30);
        // R9 + R6: reset value of an addressed register
        rd_burst(1'b1, 8'h03, 1, got);
        check("R9 reset value reg3", got[7:0], 8'h33);

        // Table walk: write then repeated-START read (R3, R4, R6)
        foreach (VEC[k]) begin
            wr_burst(VEC[k].ptr, 1, {16'h0, VEC[k].data}, ok);
            check("R4 write acks", ok, 1'b1);
            rd_burst(1'b1, VEC[k].ptr, 1, got);
            check("R6 read back selected register", got[7:0], model[VEC[k].ptr[2:0]]);
        end

        // R2: foreign address is not acknowledged, nor is the following byte
        i2c_start();
        send_byte({7'h52, 1'b0}, a);
        check("R2 foreign address nack", a, 1'b0);
        send_byte(8'h00, a);
        check("R2 later byte ignored", a, 1'b0);
        i2c_stop();

        // R1: strap pins pick the low address bits
        strap = 2'b01;
        wclk(4);
        i2c_start();
        send_byte({7'h51, 1'b0}, a);
        check("R1 strapped address 51 acked", a, 1'b1);
        i2c_stop();
        i2c_start();
        send_byte({7'h53, 1'b0}, a);
        check("R1 old address 53 not acked", a, 1'b0);
        i2c_stop();
        strap = 2'b11;
        wclk(4);

        // R5: auto-increment across the end of the bank
        wr_burst(8'h06, 3, 24'h332211, ok);
        check("R5 burst write acks", ok, 1'b1);
        rd_burst(1'b1, 8'h06, 3, got);
        check("R5 burst byte at 6", got[7:0], 8'h11);
        check("R5 burst byte at 7", got[15:8], 8'h22);
        check("R5 burst byte wrapped to 0", got[23:16], 8'h33);

        // R6: pointer (now 1) survives the STOP
        rd_burst(1'b0, 8'h00, 1, got);
        check("R6 pointer kept across stop", got[7:0], model[1]);

        // R7: controller NACK releases SDA until next START
        i2c_start();
        send_byte({DUT_ADDR, 1'b1}, a);
        recv_byte(1'b0, b);
        ok = 1'b1;
        for (int i = 0; i < 9; i++) begin
            clock_bit(1'b1, r);
            ok &= r;
        end
        check("R7 sda released after nack", ok, 1'b1);
        i2c_stop();

        // R8: STOP part-way through a data byte writes nothing
        i2c_start();
        send_byte({DUT_ADDR, 1'b0}, a);
        send_byte(8'h02, a);
        for (int i = 0; i < 4; i++) clock_bit(1'b0, r);
        i2c_stop();
        rd_burst(1'b1, 8'h02, 1, got);
        check("R8 stop mid-byte no write", got[7:0], model[2]);

        // R8: repeated START part-way through the address byte re-matches
        i2c_start();
        clock_bit(1'b1, r);
        clock_bit(1'b0, r);
        clock_bit(1'b1, r);
        i2c_start();
        send_byte({DUT_ADDR, 1'b0}, a);
        check("R8 address acked after restart", a, 1'b1);
        send_byte(8'h04, a);
        send_byte(8'h77, a);
        model[4] = 8'h77;
        i2c_stop();
        rd_burst(1'b1, 8'h04, 1, got);
        check("R8 write after restart", got[7:0], 8'h77);

        // R10: clock stretching while the bank is not ready
        stretch_max = 0;
        bank_ready  = 1'b0;
        fork
            wr_burst(8'h03, 1, 24'h00009C, ok);
            begin
                wclk(400);
                check("R10 scl held low", scl_bus, 1'b0);
                bank_ready = 1'b1;
            end
        join
        check("R10 controller waited", stretch_max >= 100, 1'b1);
        check("R10 write through stretch", ok, 1'b1);
        rd_burst(1'b1, 8'h03, 1, got);
        check("R10 stretched write landed", got[7:0], 8'h9C);
        check("R10 scl released", scl_drive_low, 1'b0);

        finish_run();
    end

endmodule